// File: doc/BRIEF.md
# Arithmetic Right Shift Execution Unit

This unit executes one instruction of a 16-bit processor: an arithmetic shift right by one or two places on one of four general registers. A start strobe presents a 16-bit instruction word. When the word is the shift instruction and the unit is idle, the unit takes the selected register's value as its operand and then runs for a fixed number of cycles. The count is 6 for a one-place shift and 8 for a two-place shift. In the last of those cycles it writes the shifted value back to the same register, updates the sign and zero flags and pulses done.

The four registers sit inside the unit. A combinational read port lets them be observed and a clocked load port lets them be preset. While busy is high the unit cannot be interrupted. Surrounding logic holds off any interrupt for as long as busy is asserted.

Top module: `asr_unit`

## Requirements
- R1: A start is accepted only when instrWord lies in 0x0068 to 0x006F, that is, bits 15:3 equal 0b0000000001101. Any other word has no effect.
- R2: Bit 2 of the word picks the shift. A 0 gives a result of {op[15], op[15:1]}. A 1 gives {op[15], op[15], op[15:2]}.
- R3: Bits 1:0 of the word pick the register (0 to 3). The result is written to that register only, and the other three keep their values.
- R4: After write-back, zeroFlag is 1 exactly when the 16-bit result is zero.
- R5: After write-back, signFlag equals bit 15 of the result, which is also bit 15 of the operand.
- R6: busy rises on the cycle after an accepted start. It stays high for 6 cycles on a one-place shift and 8 cycles on a two-place shift.
- R7: done is high for exactly one cycle, the last busy cycle. The register and flag updates become visible in the following cycle.
- R8: After reset, all registers, both flags, busy and done are 0. The flags change only at a write-back.
- R9: A start carrying a non-matching word leaves busy, the registers and the flags unchanged.
- R10: A start that arrives while busy is ignored, and the running operation completes with its original register, shift and length.
- R11: The operand is the register value at the edge where the start is accepted. A load (ldEn) writes ldData into register ldSel at the clock edge, except in the done cycle, when the load is ignored.
- R12: rdData shows register rdSel combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startStb | input | 1 | Start request for instrWord |
| instrWord | input | 16 | Instruction word to decode |
| ldEn | input | 1 | Register load enable |
| ldSel | input | 2 | Register selected for load |
| ldData | input | 16 | Load value |
| rdSel | input | 2 | Register selected for read |
| rdData | output | 16 | Value of the selected register |
| signFlag | output | 1 | Sign of the last result |
| zeroFlag | output | 1 | Last result was zero |
| busy | output | 1 | Operation in progress; no interrupt taken |
| done | output | 1 | Final cycle of an operation |

## Verification
The assertions assume that instrWord and startStb are steady around the clock edge, and that reset is held for at least one edge before activity starts. They do not assume the absence of starts during busy, or of loads in the done cycle. The stimulus changes inputs only a short time after each rising edge. It deliberately issues starts while busy, non-matching words just outside the opcode range, and loads that land in the done cycle. This exercises the ignore paths rather than avoiding them.

// File: rtl/asr_pkg.sv
package asr_pkg;
  localparam int unsigned INSTR_W    = 16;
  localparam int unsigned OPC_LSB    = 3;
  localparam int unsigned PREFIX_W   = INSTR_W - OPC_LSB;
  localparam logic [PREFIX_W-1:0] OPC_PREFIX = PREFIX_W'('h00D);
  localparam int unsigned SHIFT_BIT  = 2;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned NUM_REGS   = 1 << SEL_W;

  typedef struct packed {
    logic             capture;
    logic             writeBack;
    logic             twoPlaces;
    logic [SEL_W-1:0] tgt;
  } asrCtl_t;
endpackage

// File: rtl/asr_ctrl.sv
module asr_ctrl
  import asr_pkg::*;
#(
  parameter int unsigned CYC_ONE = 6,
  parameter int unsigned CYC_TWO = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startStb,
  input  logic [INSTR_W-1:0] instrWord,
  output asrCtl_t            ctl,
  output logic               busy,
  output logic               done
);
  localparam int unsigned CNT_W = $clog2(CYC_TWO + 1);

  logic             busyQ, twoQ, match, accept;
  logic [SEL_W-1:0] tgtQ;
  logic [CNT_W-1:0] remain, elapsed;

  assign match  = (instrWord[INSTR_W-1:OPC_LSB] == OPC_PREFIX);
  assign accept = startStb && !busyQ && match;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      twoQ   <= 1'b0;
      tgtQ   <= '0;
      remain <= '0;
    end else if (accept) begin
      busyQ  <= 1'b1;
      twoQ   <= instrWord[SHIFT_BIT];
      tgtQ   <= instrWord[SEL_W-1:0];
      remain <= instrWord[SHIFT_BIT] ? CNT_W'(CYC_TWO - 1) : CNT_W'(CYC_ONE - 1);
    end else if (busyQ) begin
      if (remain == '0) busyQ <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  // elapsed busy cycles, kept for the length check below
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       elapsed <= '0;
    else if (accept) elapsed <= CNT_W'(1);
    else if (busyQ)  elapsed <= elapsed + 1'b1;
  end

  assign busy          = busyQ;
  assign done          = busyQ && (remain == '0);
  assign ctl.capture   = accept;
  assign ctl.writeBack = done;
  assign ctl.twoPlaces = twoQ;
  assign ctl.tgt       = accept ? instrWord[SEL_W-1:0] : tgtQ;

  a_r6_rise_after_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startStb && match));

  a_r6_length: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (elapsed == (twoQ ? CNT_W'(CYC_TWO) : CNT_W'(CYC_ONE))));

  a_r7_single_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);

  a_r10_hold_selection: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> ($stable(tgtQ) && $stable(twoQ)));
endmodule

// File: rtl/asr_datapath.sv
module asr_datapath
  import asr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  asrCtl_t           ctl,
  input  logic              ldEn,
  input  logic [SEL_W-1:0]  ldSel,
  input  logic [DATA_W-1:0] ldData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              signFlag,
  output logic              zeroFlag
);
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] opQ, result;

  assign result = ctl.twoPlaces ? {{2{opQ[DATA_W-1]}}, opQ[DATA_W-1:2]}
                                : {opQ[DATA_W-1], opQ[DATA_W-1:1]};

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= '0;
      else if (ctl.writeBack && ctl.tgt == SEL_W'(i))
        q <= result;
      else if (ldEn && !ctl.writeBack && ldSel == SEL_W'(i))
        q <= ldData;
    end
    assign regFile[i] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            opQ <= '0;
    else if (ctl.capture) opQ <= regFile[ctl.tgt];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      signFlag <= 1'b0;
      zeroFlag <= 1'b0;
    end else if (ctl.writeBack) begin
      signFlag <= result[DATA_W-1];
      zeroFlag <= (result == '0);
    end
  end

  assign rdData = regFile[rdSel];

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.writeBack |=> $stable({signFlag, zeroFlag}));

  a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeBack |=> (signFlag == $past(opQ[DATA_W-1])));

  a_r4_zero_matches_reg: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeBack |=> (zeroFlag == (regFile[$past(ctl.tgt)] == '0)));

  a_r11_operand_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(opQ));
endmodule

// File: rtl/asr_unit.sv
module asr_unit
  import asr_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CYC_ONE = 6,
  parameter int unsigned CYC_TWO = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startStb,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               ldEn,
  input  logic [SEL_W-1:0]   ldSel,
  input  logic [DATA_W-1:0]  ldData,
  input  logic [SEL_W-1:0]   rdSel,
  output logic [DATA_W-1:0]  rdData,
  output logic               signFlag,
  output logic               zeroFlag,
  output logic               busy,
  output logic               done
);
  asrCtl_t ctl;

  asr_ctrl #(.CYC_ONE(CYC_ONE), .CYC_TWO(CYC_TWO)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .instrWord(instrWord),
    .ctl(ctl), .busy(busy), .done(done)
  );

  asr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .ldEn(ldEn), .ldSel(ldSel), .ldData(ldData),
    .rdSel(rdSel), .rdData(rdData),
    .signFlag(signFlag), .zeroFlag(zeroFlag)
  );
endmodule

// File: tb/sim_asr_unit.sv
module sim_asr_unit;
  logic        clk = 1'b0;
  logic        rstN, startStb, ldEn;
  logic [15:0] instrWord, ldData, rdData;
  logic [1:0]  ldSel, rdSel;
  logic        signFlag, zeroFlag, busy, done;
  int nRun = 0, nFail = 0;
  bit cmpEn = 0;

  always #10 clk = ~clk;

  asr_unit u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .instrWord(instrWord),
    .ldEn(ldEn), .ldSel(ldSel), .ldData(ldData), .rdSel(rdSel), .rdData(rdData),
    .signFlag(signFlag), .zeroFlag(zeroFlag), .busy(busy), .done(done)
  );

  // behavioural reference model
  logic [15:0] mReg [4];
  logic        mSign, mZero, mBusy, mTwo;
  logic [1:0]  mTgt;
  logic [15:0] mOp;
  int          mRemain;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) mReg[i] = 16'h0;
      mSign = 0; mZero = 0; mBusy = 0; mTwo = 0; mTgt = 0; mOp = 0; mRemain = 0;
    end else begin
      logic wb, acc;
      logic [15:0] pre, r;
      pre = mReg[instrWord[1:0]];
      wb  = mBusy && mRemain == 1;
      acc = startStb && !mBusy && instrWord >= 16'h0068 && instrWord <= 16'h006F;
      if (wb) begin
        r = $signed(mOp) >>> (mTwo ? 2 : 1);
        mReg[mTgt] = r;
        mSign = r[15];
        mZero = (r == 16'h0);
        mBusy = 0;
      end else if (mBusy) mRemain--;
      if (ldEn && !wb) mReg[ldSel] = ldData;
      if (acc) begin
        mBusy = 1; mTwo = instrWord[2]; mTgt = instrWord[1:0];
        mOp = pre; mRemain = instrWord[2] ? 8 : 6;
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmpEn) begin
    chk("R6 busy", {15'b0, busy}, {15'b0, mBusy});
    chk("R7 done", {15'b0, done}, {15'b0, mBusy && mRemain == 1});
    chk("R5 sign", {15'b0, signFlag}, {15'b0, mSign});
    chk("R4 zero", {15'b0, zeroFlag}, {15'b0, mZero});
    chk("R3 R12 read", rdData, mReg[rdSel]);
  end

  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic loadReg(logic [1:0] s, logic [15:0] v);
    ldEn = 1; ldSel = s; ldData = v; tick(); ldEn = 0;
  endtask

  // issue a start and return the number of busy cycles seen
  task automatic runOp(logic [15:0] w, output int n);
    startStb = 1; instrWord = w; tick(); startStb = 0; instrWord = 16'h0;
    n = 0;
    while (busy && n < 50) begin n++; tick(); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int n;
    rstN = 0; startStb = 0; instrWord = 0; ldEn = 0; ldSel = 0; ldData = 0; rdSel = 0;
    repeat (3) @(posedge clk);
    #3;
    for (int i = 0; i < 4; i++) begin
      rdSel = 2'(i); #1;
      chk("R8 reset reg", rdData, 16'h0);
    end
    chk("R8 reset status", {12'b0, busy, done, signFlag, zeroFlag}, 16'h0);
    rstN = 1; cmpEn = 1; tick();

    // two-place shift of a negative value on R1
    loadReg(2'd1, 16'h8001);
    runOp(16'h006D, n);
    chk("R6 two-place length", 16'(n), 16'd8);
    rdSel = 1; #1;
    chk("R2 two-place result", rdData, 16'hE000);
    chk("R5 sign set", {15'b0, signFlag}, 16'h1);

    // one-place shift on R0, positive
    loadReg(2'd0, 16'h7FFE);
    runOp(16'h0068, n);
    chk("R6 one-place length", 16'(n), 16'd6);
    rdSel = 0; #1;
    chk("R2 one-place result", rdData, 16'h3FFF);
    chk("R5 sign clear", {15'b0, signFlag}, 16'h0);
    rdSel = 1; #1;
    chk("R3 other reg kept", rdData, 16'hE000);

    // shift to zero on R2
    loadReg(2'd2, 16'h0003);
    runOp(16'h006E, n);
    rdSel = 2; #1;
    chk("R4 zero result", rdData, 16'h0);
    chk("R4 zero flag", {15'b0, zeroFlag}, 16'h1);

    // non-matching words just outside the range
    runOp(16'h0067, n);
    chk("R9 below range ignored", 16'(n), 16'd0);
    runOp(16'h0070, n);
    chk("R9 above range ignored", 16'(n), 16'd0);
    runOp(16'h8068, n);
    chk("R1 high bits must match", 16'(n), 16'd0);
    chk("R9 flags kept", {14'b0, signFlag, zeroFlag}, 16'h1);

    // start while busy, plus load landing in the done cycle
    loadReg(2'd3, 16'h0100);
    startStb = 1; instrWord = 16'h006B; tick();
    instrWord = 16'h006C; tick(); tick();
    startStb = 0; instrWord = 0;
    ldData = 16'h1234; ldSel = 3; ldEn = 1; tick(); ldEn = 0;
    n = 0;
    while (!done && n < 20) begin n++; tick(); end
    ldEn = 1; ldSel = 0; ldData = 16'hAAAA; tick(); ldEn = 0;
    chk("R10 run completed", {15'b0, busy}, 16'h0);
    rdSel = 3; #1;
    chk("R11 operand from start edge", rdData, 16'h0080);
    rdSel = 0; #1;
    chk("R11 load in done cycle ignored", rdData, 16'h3FFF);

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] rv;
      rv = $urandom;
      startStb = rv[0] & rv[1];
      instrWord = rv[2] ? {13'h000D, rv[5:3]} : {8'h00, rv[12:5]};
      ldEn = rv[13] & rv[14] & rv[15];
      ldSel = rv[17:16];
      ldData = rv[18] ? {rv[19], 15'h0} : 16'($urandom);
      rdSel = rv[21:20];
      tick();
    end
    startStb = 0; ldEn = 0;
    repeat (12) tick();
    cmpEn = 0;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule